// File: doc/BRIEF.md
# Parallel Bitstream Configuration Loader

This block is a hardware master that pushes a byte-wide configuration image into a programmable target over an 8-bit parallel slave port. A single start pulse, with the total byte count beside it, begins a load. The block pulses the target's program pin and waits for the target to report that it is ready. It then raises chip-select and write-enable and streams the bytes. Each byte is launched on a falling edge of the configuration clock and the target takes it on the next rising edge. The target pins are active-high at this boundary.

Image bytes arrive on a valid/ready stream. A byte is taken only when `s_valid` and `s_ready` are both high on a rising system clock. `s_ready` is raised for a single cycle, at the end of a configuration-clock high phase, and only when bytes remain and the target has not refused the previous byte. The source may hold `s_valid` low for as long as it needs. The configuration clock then simply stays high and nothing is lost.

When the data is finished, the loader drops chip-select and then write-enable. It keeps toggling the configuration clock until the target raises its done pin. Three phases have a cycle-count timeout: the ready wait, the busy hold and the done wait. A timeout ends the load with an abort pulse and a code that names the phase.

Top module: `cfg_loader`

## Requirements
- R1: After reset, `tgt_prog`, `tgt_cs`, `tgt_wr`, `s_ready`, `abort_o` are low, `tgt_cclk` is high and `status` is 0 (idle).
- R2: A start pulse in idle holds `tgt_prog` high for PROG_TICKS*DIV cycles and then releases it. `status` reads 1 (working) from then until the result.
- R3: After program is released, the loader waits as long as `tgt_init_pend` and `tgt_busy` are both high. Once either one is low, it raises `tgt_cs` and `tgt_wr` together while `tgt_cclk` is high.
- R4: Each byte is put on `tgt_data` as `tgt_cclk` falls and is held across the following rise. The target sees the bytes in stream order, each exactly once, with no extras.
- R5: `s_ready` is high only while `tgt_cclk` and `tgt_cs` are high, and only while bytes remain.
- R6: With BUSY_CHECK set, if `tgt_busy` is high at the end of the high phase after a byte's rising edge, the same byte is clocked again without taking a new one.
- R7: After the last byte, `tgt_cs` falls first, and `tgt_wr` falls DIV cycles later.
- R8: After write-enable drops, the clock keeps toggling until `tgt_done` is seen high in a high phase. `status` then shows 2 (success) for one cycle and returns to 0.
- R9: Timeout codes: 3 if the ready wait exceeds TIMEOUT cycles, 4 if a busy hold exceeds it, 5 if the done wait exceeds it. Each is shown for one cycle with `abort_o` high, and it drops chip-select and write-enable.
- R10: A start pulse while a load is in progress is ignored. The load produces exactly one result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a load |
| byte_count | input | CNT_W | Number of image bytes, sampled with start |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | DW | Stream byte |
| s_ready | output | 1 | Stream byte taken this cycle when valid |
| tgt_prog | output | 1 | Target program request |
| tgt_cs | output | 1 | Target chip-select |
| tgt_wr | output | 1 | Target write-enable |
| tgt_cclk | output | 1 | Configuration clock |
| tgt_data | output | DW | Configuration data bus |
| tgt_init_pend | input | 1 | Target still initialising |
| tgt_busy | input | 1 | Target refused the last byte / not ready |
| tgt_done | input | 1 | Target configured |
| abort_o | output | 1 | One-cycle abort on a timeout |
| status | output | 3 | 0 idle, 1 working, 2 success, 3 ready-wait timeout, 4 busy timeout, 5 done timeout |

## Verification
Program is released PROG_TICKS*DIV cycles after the start is sampled. A byte reaches the target on the configuration clock rise that comes DIV cycles after its stream handshake. The result code shows for the single cycle after the deciding tick. A timeout result follows TIMEOUT cycles after the phase began. The bench samples every pin on the falling system edge. The scoreboard pops the expected byte at the moment the modelled target takes it on a rising configuration clock. Pulse widths and edge spacings are measured in system cycles and compared with those counts.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WORK    = 3'd1,
    ST_OK      = 3'd2,
    ST_INIT_TO = 3'd3,
    ST_BUSY_TO = 3'd4,
    ST_DONE_TO = 3'd5
  } cfgl_status_e;

  typedef enum logic [3:0] {
    F_IDLE,
    F_PROG,
    F_WREADY,
    F_SETUP,
    F_HI,
    F_LO,
    F_CSOFF,
    F_WROFF,
    F_DHI,
    F_DLO,
    F_REPORT
  } cfgl_state_e;

endpackage

// File: rtl/cfgl_tick.sv
module cfgl_tick #(
  parameter int DIV = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) cnt <= '0;
    else if (cnt == LAST)  cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);

  assert_tick_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/cfgl_wdog.sv
module cfgl_wdog #(
  parameter int TIMEOUT = 2_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int W = $clog2(TIMEOUT + 1);
  localparam logic [W-1:0] LAST = W'(TIMEOUT - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run)     cnt <= '0;
    else if (cnt != LAST)   cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == LAST);

  assert_wdog_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/cfgl_bytecnt.sv
module cfgl_bytecnt #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] value,
  input  logic             dec,
  output logic             empty
);
  logic [CNT_W-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n)     left <= '0;
    else if (load)  left <= value;
    else if (dec)   left <= left - 1'b1;
  end

  assign empty = (left == '0);

  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> !empty);
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfgl_pkg::*;
#(
  parameter int DW         = 8,
  parameter int CNT_W      = 24,
  parameter int DIV        = 1,
  parameter int TIMEOUT    = 2_000_000,
  parameter int PROG_TICKS = 4,
  parameter bit BUSY_CHECK = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] byte_count,
  input  logic             s_valid,
  input  logic [DW-1:0]    s_data,
  output logic             s_ready,
  output logic             tgt_prog,
  output logic             tgt_cs,
  output logic             tgt_wr,
  output logic             tgt_cclk,
  output logic [DW-1:0]    tgt_data,
  input  logic             tgt_init_pend,
  input  logic             tgt_busy,
  input  logic             tgt_done,
  output logic             abort_o,
  output logic [2:0]       status
);
  localparam int PW = (PROG_TICKS > 1) ? $clog2(PROG_TICKS) : 1;
  localparam logic [PW-1:0] PLAST = PW'(PROG_TICKS - 1);

  cfgl_state_e  state;
  cfgl_status_e result;
  logic [PW-1:0] pcnt;
  logic pending, hold;
  logic tick, wd_exp, wd_run, empty, busy_seen, accept, in_data;

  cfgl_tick #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(state == F_IDLE), .tick(tick));

  assign in_data = (state == F_HI) || (state == F_LO);
  assign wd_run  = (state == F_WREADY) || (state == F_DHI) ||
                   (state == F_DLO) || (hold && in_data);

  cfgl_wdog #(.TIMEOUT(TIMEOUT)) u_wdog (
    .clk(clk), .rst_n(rst_n), .run(wd_run), .expired(wd_exp));

  generate
    if (BUSY_CHECK) begin : g_busy
      assign busy_seen = pending && tgt_busy;
    end else begin : g_nobusy
      assign busy_seen = 1'b0;
    end
  endgenerate

  assign s_ready = (state == F_HI) && tick && !busy_seen && !empty;
  assign accept  = s_ready && s_valid;

  cfgl_bytecnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .load((state == F_IDLE) && start), .value(byte_count),
    .dec(accept), .empty(empty));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= F_IDLE;
      result   <= ST_IDLE;
      pcnt     <= '0;
      pending  <= 1'b0;
      hold     <= 1'b0;
      tgt_prog <= 1'b0;
      tgt_cs   <= 1'b0;
      tgt_wr   <= 1'b0;
      tgt_cclk <= 1'b1;
      tgt_data <= '0;
    end else begin
      case (state)
        F_IDLE: if (start) begin
          tgt_prog <= 1'b1;
          pcnt     <= '0;
          state    <= F_PROG;
        end
        F_PROG: if (tick) begin
          if (pcnt == PLAST) begin
            tgt_prog <= 1'b0;
            state    <= F_WREADY;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        F_WREADY: begin
          if (tick && !(tgt_init_pend && tgt_busy)) begin
            state <= F_SETUP;
          end else if (wd_exp) begin
            result <= ST_INIT_TO;
            state  <= F_REPORT;
          end
        end
        F_SETUP: if (tick) begin
          tgt_cs   <= 1'b1;
          tgt_wr   <= 1'b1;
          tgt_cclk <= 1'b1;
          pending  <= 1'b0;
          hold     <= 1'b0;
          state    <= F_HI;
        end
        F_HI: begin
          if (hold && wd_exp) begin
            tgt_cs <= 1'b0;
            tgt_wr <= 1'b0;
            hold   <= 1'b0;
            result <= ST_BUSY_TO;
            state  <= F_REPORT;
          end else if (tick) begin
            if (busy_seen) begin
              tgt_cclk <= 1'b0;
              hold     <= 1'b1;
              state    <= F_LO;
            end else if (empty) begin
              pending <= 1'b0;
              hold    <= 1'b0;
              state   <= F_CSOFF;
            end else if (s_valid) begin
              tgt_data <= s_data;
              tgt_cclk <= 1'b0;
              pending  <= 1'b1;
              hold     <= 1'b0;
              state    <= F_LO;
            end else begin
              pending <= 1'b0;
              hold    <= 1'b0;
            end
          end
        end
        F_LO: begin
          if (hold && wd_exp) begin
            tgt_cs   <= 1'b0;
            tgt_wr   <= 1'b0;
            tgt_cclk <= 1'b1;
            hold     <= 1'b0;
            result   <= ST_BUSY_TO;
            state    <= F_REPORT;
          end else if (tick) begin
            tgt_cclk <= 1'b1;
            state    <= F_HI;
          end
        end
        F_CSOFF: if (tick) begin
          tgt_cs <= 1'b0;
          state  <= F_WROFF;
        end
        F_WROFF: if (tick) begin
          tgt_wr <= 1'b0;
          state  <= F_DHI;
        end
        F_DHI: begin
          if (tick && tgt_done) begin
            result <= ST_OK;
            state  <= F_REPORT;
          end else if (wd_exp) begin
            result <= ST_DONE_TO;
            state  <= F_REPORT;
          end else if (tick) begin
            tgt_cclk <= 1'b0;
            state    <= F_DLO;
          end
        end
        F_DLO: begin
          if (wd_exp) begin
            tgt_cclk <= 1'b1;
            result   <= ST_DONE_TO;
            state    <= F_REPORT;
          end else if (tick) begin
            tgt_cclk <= 1'b1;
            state    <= F_DHI;
          end
        end
        F_REPORT: begin
          result <= ST_IDLE;
          state  <= F_IDLE;
        end
        default: state <= F_IDLE;
      endcase
    end
  end

  always_comb begin
    if (state == F_IDLE)        status = ST_IDLE;
    else if (state == F_REPORT) status = result;
    else                        status = ST_WORK;
  end

  assign abort_o = (state == F_REPORT) && (result != ST_OK);

  // Guarding assertions
  assert_cs_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tgt_cs) && !abort_o) |-> tgt_wr);
  assert_wr_after_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tgt_wr) |-> !tgt_cs);
  assert_data_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tgt_cclk) && tgt_cs) |-> $stable(tgt_data));
  assert_ready_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (tgt_cclk && tgt_cs));
  assert_abort_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> (status == ST_INIT_TO || status == ST_BUSY_TO || status == ST_DONE_TO));
  assert_prog_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_prog |-> (!tgt_cs && !tgt_wr));
  assert_ok_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (status == ST_OK) |=> (status == ST_IDLE));
  assert_refused_byte_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == F_HI && tick && busy_seen && !(hold && wd_exp)) |=> $stable(tgt_data));
endmodule

// File: tb/cfg_loader_test.sv
`timescale 1ns/1ps
module cfg_loader_test;
  localparam int DIV = 2, TMO = 60, PT = 2;

  logic clk = 0, rst_n = 0, start = 0, s_valid = 0;
  logic [7:0] byte_count = 0, s_data = 0, tgt_data;
  logic s_ready, tgt_prog, tgt_cs, tgt_wr, tgt_cclk, tgt_busy, abort_o;
  logic [2:0] status;
  logic init_pend = 0, ibusy = 0, brf = 0, done_on = 0;

  always #2.5 clk = ~clk;

  cfg_loader #(.DW(8), .CNT_W(8), .DIV(DIV), .TIMEOUT(TMO), .PROG_TICKS(PT),
               .BUSY_CHECK(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .tgt_prog(tgt_prog), .tgt_cs(tgt_cs), .tgt_wr(tgt_wr), .tgt_cclk(tgt_cclk),
    .tgt_data(tgt_data), .tgt_init_pend(init_pend), .tgt_busy(tgt_busy),
    .tgt_done(done_on), .abort_o(abort_o), .status(status));

  assign tgt_busy = ibusy | brf;

  int nchk = 0, nfail = 0, cyc = 0;
  logic [7:0] exp_q[$];

  task automatic chk(bit ok, string req, int act, int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Target model: init / done on system clock
  int init_dly = 10, init_ctr = 0, done_dly = 3, mark = 0;
  int dcount = 0, cs_edges = 0, refuse_n = 0, ref_cnt = 0;
  bit armed = 0, prev_wr = 0;

  always @(posedge clk) begin
    if (tgt_prog) begin
      init_pend <= 1; ibusy <= 1; init_ctr <= 0; done_on <= 0; armed <= 0;
    end else if (init_pend) begin
      if (init_ctr + 1 >= init_dly) begin init_pend <= 0; ibusy <= 0; end
      init_ctr <= init_ctr + 1;
    end
    prev_wr <= tgt_wr;
    if (prev_wr && !tgt_wr && !tgt_prog) begin mark <= dcount + done_dly; armed <= 1; end
    else if (armed && dcount >= mark && !tgt_prog) done_on <= 1;
  end

  // Target model: data capture on the configuration clock, scoreboard pop
  always @(posedge tgt_cclk) begin
    if (tgt_cs === 1'b1 && tgt_wr === 1'b1) begin
      cs_edges++;
      if (ref_cnt < refuse_n) begin
        ref_cnt++; brf <= 1;
      end else begin
        ref_cnt = 0; brf <= 0;
        if (exp_q.size() == 0) chk(0, "R4 extra byte", tgt_data, -1);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(tgt_data == e, "R4 byte order", tgt_data, e);
        end
      end
    end else if (tgt_cs === 1'b0) dcount++;
  end

  // Pin monitor on the falling edge
  bit got_result = 0, last_abort = 0, prev_init = 0, prev_cs = 0, prev_wr_n = 0;
  bit cclk_at_cs = 0, saw_work = 0;
  int res_count = 0, last_status = 0, prog_len = 0, ready_bad = 0;
  int init_fall_t = 0, cs_rise_t = 0, cs_fall_t = 0, wr_fall_t = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (status != 0 && status != 1) begin
        got_result = 1; res_count++; last_status = status; last_abort = abort_o;
      end
      if (status == 1 && tgt_cs) saw_work = 1;
      if (tgt_prog) prog_len++;
      if (s_ready && !(tgt_cclk && tgt_cs)) ready_bad++;
      if (prev_init && !init_pend) init_fall_t = cyc;
      if (!prev_cs && tgt_cs) begin cs_rise_t = cyc; cclk_at_cs = tgt_cclk && tgt_wr; end
      if (prev_cs && !tgt_cs) cs_fall_t = cyc;
      if (prev_wr_n && !tgt_wr) wr_fall_t = cyc;
    end
    prev_init = init_pend; prev_cs = tgt_cs; prev_wr_n = tgt_wr;
  end

  task automatic kick(int n);
    @(negedge clk); byte_count = 8'(n); start = 1;
    @(negedge clk); start = 0;
  endtask

  // Driver: pushes each byte to the expected queue at its handshake
  task automatic send(int n, int gap, logic [7:0] seed, bit mid_start);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      if (got_result) break;
      d = seed + 8'(i * 37);
      @(negedge clk); s_valid = 1; s_data = d;
      while (!s_ready && !got_result) @(negedge clk);
      if (got_result) break;
      @(posedge clk); exp_q.push_back(d);
      #1 s_valid = 0;
      if (mid_start && i == 1) begin
        @(negedge clk); start = 1; @(negedge clk); start = 0;   // R10 stray start
      end
      repeat (gap) @(negedge clk);
    end
    s_valid = 0;
  endtask

  task automatic wait_result();
    int n = 0;
    while (!got_result && n < 5000) begin @(negedge clk); n++; end
    chk(got_result, "R8 result produced", got_result, 1);
  endtask

  int dc0 = 0, ce0 = 0;
  task automatic do_load(int n, int gap, logic [7:0] seed, bit mid_start);
    got_result = 0; res_count = 0; prog_len = 0; saw_work = 0; ready_bad = 0;
    dc0 = dcount; ce0 = cs_edges;
    fork
      begin kick(n); send(n, gap, seed, mid_start); end
      wait_result();
    join
    repeat (4) @(negedge clk);
  endtask

  task automatic check_ok(string tag);
    chk(last_status == 2, {tag, " R8 success code"}, last_status, 2);
    chk(!last_abort, {tag, " R8 no abort"}, last_abort, 0);
    chk(exp_q.size() == 0, {tag, " R4 all bytes seen"}, exp_q.size(), 0);
    chk(status == 0, {tag, " R8 back to idle"}, status, 0);
    chk(res_count == 1, {tag, " R10 single result"}, res_count, 1);
    chk(ready_bad == 0, {tag, " R5 ready only in high phase"}, ready_bad, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(!tgt_prog && !tgt_cs && !tgt_wr, "R1 control pins low", {tgt_prog, tgt_cs, tgt_wr}, 0);
    chk(tgt_cclk == 1, "R1 clock idles high", tgt_cclk, 1);
    chk(!s_ready && !abort_o, "R1 ready/abort low", {s_ready, abort_o}, 0);
    chk(status == 0, "R1 idle status", status, 0);
    rst_n = 1;
    @(negedge clk);

    // plain load
    do_load(8, 0, 8'h11, 0);
    check_ok("T1");
    chk(prog_len == PT * DIV, "R2 program width", prog_len, PT * DIV);
    chk(saw_work, "R2 working status", saw_work, 1);
    chk(cs_rise_t > init_fall_t, "R3 select after ready", cs_rise_t, init_fall_t + 1);
    chk(cclk_at_cs, "R3 clock high and write on at select", cclk_at_cs, 1);
    chk(wr_fall_t - cs_fall_t == DIV, "R7 select then write off", wr_fall_t - cs_fall_t, DIV);
    chk(dcount - dc0 == done_dly, "R8 trailing clocks until done", dcount - dc0, done_dly);

    // busy refusals
    refuse_n = 2;
    do_load(5, 0, 8'hA0, 0);
    check_ok("T2");
    chk(cs_edges - ce0 == 15, "R6 refused bytes reclocked", cs_edges - ce0, 15);
    refuse_n = 0;

    // stream gaps with a stray start
    do_load(6, 3, 8'h3C, 1);
    check_ok("T3 R5 gaps");

    // one byte
    do_load(1, 0, 8'hE7, 0);
    check_ok("T4");

    // ready wait timeout
    init_dly = 100000;
    do_load(3, 0, 8'h01, 0);
    chk(last_status == 3, "R9 ready timeout code", last_status, 3);
    chk(last_abort, "R9 ready timeout abort", last_abort, 1);
    chk(cs_edges == ce0, "R9 no data sent", cs_edges - ce0, 0);
    chk(!tgt_cs && !tgt_wr, "R9 pins released", {tgt_cs, tgt_wr}, 0);
    exp_q.delete(); init_dly = 10;

    // busy timeout
    refuse_n = 1000000;
    do_load(3, 0, 8'h55, 0);
    chk(last_status == 4, "R9 busy timeout code", last_status, 4);
    chk(last_abort, "R9 busy timeout abort", last_abort, 1);
    chk(!tgt_cs && !tgt_wr, "R9 pins released after busy", {tgt_cs, tgt_wr}, 0);
    exp_q.delete(); refuse_n = 0;

    // done timeout
    done_dly = 100000;
    do_load(4, 0, 8'h77, 0);
    chk(last_status == 5, "R9 done timeout code", last_status, 5);
    chk(last_abort, "R9 done timeout abort", last_abort, 1);
    chk(exp_q.size() == 0, "R4 bytes before done timeout", exp_q.size(), 0);
    done_dly = 3;

    // recovery
    do_load(4, 1, 8'hC3, 0);
    check_ok("T8");

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog R8 actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule